// File: doc/BRIEF.md
# Interrupt Master-Enable and Vector Dispatch

This block is the interrupt gate of a small 8-bit processor core. It keeps the global interrupt enable and the delayed-enable countdown. At every opcode fetch it decides whether the fetch is replaced by an interrupt entry. During the entry sequence it selects the service vector and pulses a clear for the request bit it served. The instruction decoder supplies one-cycle strobes for the enable, disable, return-from-interrupt and opcode-fetch events. It also supplies a level that marks the second byte of a prefixed instruction and a level that marks a jammed core. The request and enable registers arrive as plain vectors.

The source is not chosen when the interrupt is taken. It is chosen a fixed number of cycles later, near the end of the entry sequence. A request that changes during entry therefore changes the vector. A request that disappears during entry sends execution to address zero.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the global enable is clear, no countdown is pending, `take_o`, `vec_valid_o` and `clr_o` are all zero, and a fetch with an active request is not taken.
- R2: An enable strobe starts a countdown of two fetches. The first following fetch is never taken. The second fetch is taken if a request is present.
- R3: An enable strobe that arrives while a countdown is already running is ignored; the countdown is not restarted.
- R4: A return-from-interrupt strobe makes the very next fetch eligible to be taken.
- R5: A disable strobe clears the global enable and cancels any running countdown. No fetch is taken afterwards until a new enable or return strobe arrives.
- R6: A fetch with `prefix_i` high neither advances the countdown nor is taken.
- R7: A fetch with `jam_i` high is not taken. The countdown still advances and the enable is kept.
- R8: Taking an interrupt clears the global enable, so a later fetch is not taken without a new enable or return strobe.
- R9: Among the bits set in both `req_i` and `ena_i`, the lowest index k wins. The vector is 0x0040 + 8·k. `vec_valid_o` is high for exactly one cycle, which begins WAIT_CYC+1 clock edges after the edge that ends the take cycle.
- R10: The source is sampled in the cycle before `vec_valid_o` rises. If no bit is set in both `req_i` and `ena_i` then, the vector is 0x0000 and `clr_o` stays zero.
- R11: In the cycle `vec_valid_o` is high, `clr_o` has bit k set (k being the selected source) only if `req_i[k]` is still set in that cycle. No other bit of `clr_o` is set.
- R12: `irq_o` is high exactly when some bit is set in both `req_i` and `ena_i`.
- R13: Fetches that occur during an entry sequence are never taken, even if the enable has been re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_SRC | Interrupt request register |
| ena_i | input | N_SRC | Interrupt enable register |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| fetch_i | input | 1 | Opcode-fetch strobe |
| prefix_i | input | 1 | Prefixed instruction in progress |
| jam_i | input | 1 | Core is jammed |
| take_o | output | 1 | This fetch is replaced by an interrupt entry |
| irq_o | output | 1 | Some request is both set and enabled |
| vec_o | output | VEC_W | Selected vector address |
| vec_valid_o | output | 1 | One-cycle valid for `vec_o` |
| clr_o | output | N_SRC | One-hot clear for the serviced request bit |

## Verification
The bench checks the delayed enable at the exact fetch it targets. A design that enables one fetch early, restarts the countdown on a repeated enable, or counts prefixed fetches would take an interrupt at a fetch where it must not. Requests are changed or withdrawn in the sampling cycle of the entry sequence. A design that latched the source at take time would show the old vector instead of the new one or instead of 0x0000. A request dropped before the clear cycle tests the conditional clear. The enable is re-armed during entry to prove that entry blocks further takes.

// File: rtl/irq_dispatch_pkg.sv
`timescale 1ns/1ps
package irq_dispatch_pkg;

    typedef enum logic [1:0] {
        ENT_IDLE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_PICK = 2'd2,
        ENT_CLR  = 2'd3
    } ent_state_e;

    typedef struct packed {
        logic       ime;
        logic [1:0] pend;
    } en_state_t;

    function automatic int unsigned vec_addr(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned idx);
        return base + step * idx;
    endfunction

endpackage

// File: rtl/irq_master_en.sv
`timescale 1ns/1ps
module irq_master_en
    import irq_dispatch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ei_i,
    input  logic di_i,
    input  logic reti_i,
    input  logic fetch_i,
    input  logic prefix_i,
    input  logic jam_i,
    input  logic hit_i,
    input  logic idle_i,
    output logic take_o,
    output logic ime_o
);
    en_state_t st_d, st_q;
    logic      dec;
    logic [1:0] pend_after;
    logic      ime_now;

    always_comb begin
        dec        = fetch_i && !prefix_i && (st_q.pend != 2'd0);
        pend_after = dec ? st_q.pend - 2'd1 : st_q.pend;
        ime_now    = st_q.ime || (dec && st_q.pend == 2'd1);
        take_o     = fetch_i && idle_i && ime_now && hit_i && !prefix_i && !jam_i;

        st_d = st_q;
        if (di_i) begin
            st_d.ime  = 1'b0;
            st_d.pend = 2'd0;
        end else begin
            st_d.ime  = take_o ? 1'b0 : ime_now;
            st_d.pend = pend_after;
            if (reti_i) begin
                st_d.pend = 2'd1;
            end else if (ei_i && st_q.pend == 2'd0) begin
                st_d.pend = 2'd2;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ime_o = st_q.ime;
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
    parameter int N_SRC = 5,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] hits_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N_SRC-1:0] below;
    logic [N_SRC-1:0] grant;

    assign below[0] = 1'b0;
    for (genvar i = 1; i < N_SRC; i++) begin : g_chain
        assign below[i] = below[i-1] | hits_i[i-1];
    end
    assign grant   = hits_i & ~below;
    assign found_o = |hits_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
    import irq_dispatch_pkg::*;
#(
    parameter int N_SRC    = 5,
    parameter int VEC_W    = 16,
    parameter int WAIT_CYC = 2,
    parameter int VEC_BASE = 'h40,
    parameter int VEC_STEP = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             found_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [N_SRC-1:0] req_i,
    output logic             idle_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o,
    output logic [N_SRC-1:0] clr_o
);
    typedef struct packed {
        ent_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] sel;
        logic             selv;
        logic             vld;
        logic [VEC_W-1:0] vec;
    } ent_t;

    ent_t e_d, e_q;

    always_comb begin
        e_d     = e_q;
        e_d.vld = 1'b0;
        unique case (e_q.st)
            ENT_IDLE: begin
                if (take_i) begin
                    e_d.st  = ENT_WAIT;
                    e_d.cnt = '0;
                end
            end
            ENT_WAIT: begin
                e_d.cnt = e_q.cnt + CNT_W'(1);
                if (e_q.cnt == CNT_W'(WAIT_CYC - 1)) e_d.st = ENT_PICK;
            end
            ENT_PICK: begin
                e_d.st   = ENT_CLR;
                e_d.sel  = idx_i;
                e_d.selv = found_i;
                e_d.vld  = 1'b1;
                e_d.vec  = found_i ? VEC_W'(vec_addr(VEC_BASE, VEC_STEP, int'(idx_i))) : '0;
            end
            default: begin
                e_d.st = ENT_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: ENT_IDLE, default: '0};
        end else begin
            e_q <= e_d;
        end
    end

    always_comb begin
        clr_o = '0;
        if (e_q.st == ENT_CLR && e_q.selv) begin
            clr_o = (N_SRC'(1) << e_q.sel) & req_i;
        end
    end

    assign idle_o      = (e_q.st == ENT_IDLE);
    assign vec_o       = e_q.vec;
    assign vec_valid_o = e_q.vld;
endmodule

// File: rtl/irq_dispatch.sv
`timescale 1ns/1ps
module irq_dispatch #(
    parameter int N_SRC    = 5,
    parameter int VEC_W    = 16,
    parameter int WAIT_CYC = 2,
    parameter int VEC_BASE = 'h40,
    parameter int VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] ena_i,
    input  logic             ei_i,
    input  logic             di_i,
    input  logic             reti_i,
    input  logic             fetch_i,
    input  logic             prefix_i,
    input  logic             jam_i,
    output logic             take_o,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid_o,
    output logic [N_SRC-1:0] clr_o
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] hits;
    logic             found;
    logic [IDX_W-1:0] idx;
    logic             idle;
    logic             ime;

    assign hits  = req_i & ena_i;
    assign irq_o = |hits;

    irq_master_en u_en (
        .clk(clk), .rst_n(rst_n),
        .ei_i(ei_i), .di_i(di_i), .reti_i(reti_i),
        .fetch_i(fetch_i), .prefix_i(prefix_i), .jam_i(jam_i),
        .hit_i(irq_o), .idle_i(idle),
        .take_o(take_o), .ime_o(ime)
    );

    irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
        .hits_i(hits), .found_o(found), .idx_o(idx)
    );

    irq_entry_seq #(
        .N_SRC(N_SRC), .VEC_W(VEC_W), .WAIT_CYC(WAIT_CYC),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .take_i(take_o), .found_i(found), .idx_i(idx), .req_i(req_i),
        .idle_o(idle), .vec_o(vec_o), .vec_valid_o(vec_valid_o), .clr_o(clr_o)
    );
endmodule

// File: rtl/irq_dispatch_chk.sv
`timescale 1ns/1ps
module irq_dispatch_chk #(
    parameter int N_SRC = 5,
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_i,
    input logic             prefix_i,
    input logic             jam_i,
    input logic             di_i,
    input logic             take_o,
    input logic             irq_o,
    input logic             ime,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_valid_o,
    input logic [N_SRC-1:0] clr_o
);
    assert_take_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (fetch_i && !prefix_i));
    assert_take_jam_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !jam_i);
    assert_di_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        di_i |=> !take_o);
    assert_take_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !ime);
    assert_vld_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);
    assert_zero_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_o == '0) |-> (clr_o == '0));
    assert_clr_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));
    assert_clr_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |-> vec_valid_o);
    assert_take_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> irq_o);
endmodule

bind irq_dispatch irq_dispatch_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .prefix_i(prefix_i),
    .jam_i(jam_i), .di_i(di_i), .take_o(take_o), .irq_o(irq_o), .ime(ime),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o), .clr_o(clr_o)
);

// File: tb/irq_dispatch_bench.sv
`timescale 1ns/1ps
module irq_dispatch_bench;
    localparam int N = 5;
    localparam int W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req_i = '0, ena_i = '1;
    logic ei_i = 0, di_i = 0, reti_i = 0, fetch_i = 0, prefix_i = 0, jam_i = 0;
    logic take_o, irq_o, vec_valid_o;
    logic [15:0] vec_o;
    logic [N-1:0] clr_o;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irq_dispatch #(.N_SRC(N), .VEC_W(16), .WAIT_CYC(W)) u_irq_dispatch (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ena_i(ena_i),
        .ei_i(ei_i), .di_i(di_i), .reti_i(reti_i), .fetch_i(fetch_i),
        .prefix_i(prefix_i), .jam_i(jam_i), .take_o(take_o), .irq_o(irq_o),
        .vec_o(vec_o), .vec_valid_o(vec_valid_o), .clr_o(clr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ei();   ei_i = 1;   tick(); ei_i = 0;   endtask
    task automatic pulse_di();   di_i = 1;   tick(); di_i = 0;   endtask
    task automatic pulse_reti(); reti_i = 1; tick(); reti_i = 0; endtask

    task automatic do_fetch(input logic exp_take, input string tag);
        fetch_i = 1;
        #1 chk(tag, take_o, exp_take);
        tick();
        fetch_i = 0;
    endtask

    task automatic run_entry(input logic [N-1:0] pick_req, input logic [N-1:0] clr_req,
                             input logic [15:0] exp_vec, input logic [N-1:0] exp_clr,
                             input bit poke, input string tag);
        for (int i = 0; i < W; i++) begin
            if (poke && i == 0) reti_i = 1;
            if (poke && i == 1) begin
                fetch_i = 1;
                #1 chk({tag, " R13 fetch during entry"}, take_o, 1'b0);
            end
            tick();
            reti_i = 0;
            fetch_i = 0;
        end
        req_i = pick_req;
        tick();
        req_i = clr_req;
        #1;
        chk({tag, " R9 valid"}, vec_valid_o, 1'b1);
        chk({tag, " R9/R10 vector"}, vec_o, exp_vec);
        chk({tag, " R11 clear"}, clr_o, exp_clr);
        tick();
        chk({tag, " R9 valid drops"}, vec_valid_o, 1'b0);
        chk({tag, " R11 clear drops"}, clr_o, '0);
    endtask

    task automatic clean();
        pulse_di();
        req_i = '0;
        ena_i = '1;
    endtask

    task automatic t_reset();
        req_i = 5'h01;
        #1;
        chk("R1 valid at reset", vec_valid_o, 1'b0);
        chk("R1 clear at reset", clr_o, '0);
        do_fetch(1'b0, "R1 fetch after reset not taken");
        req_i = '0;
    endtask

    task automatic t_ei_delay();
        clean();
        req_i = 5'h04;
        pulse_ei();
        do_fetch(1'b0, "R2 first fetch after EI");
        do_fetch(1'b1, "R2 second fetch after EI");
        run_entry(5'h04, 5'h04, 16'h0050, 5'h04, 0, "R2 entry");
        do_fetch(1'b0, "R8 fetch after entry");
    endtask

    task automatic t_ei_repeat();
        clean();
        req_i = 5'h01;
        pulse_ei();
        do_fetch(1'b0, "R3 first fetch");
        pulse_ei();
        do_fetch(1'b1, "R3 repeated EI ignored");
        run_entry(5'h01, 5'h01, 16'h0040, 5'h01, 0, "R3 entry");
    endtask

    task automatic t_reti();
        clean();
        req_i = 5'h1A;
        pulse_reti();
        do_fetch(1'b1, "R4 fetch after RETI");
        run_entry(5'h1A, 5'h1A, 16'h0048, 5'h02, 0, "R4 priority");
    endtask

    task automatic t_di();
        clean();
        req_i = 5'h08;
        pulse_ei();
        do_fetch(1'b0, "R5 fetch before DI");
        pulse_di();
        do_fetch(1'b0, "R5 pending cancelled a");
        do_fetch(1'b0, "R5 pending cancelled b");
        pulse_reti();
        pulse_di();
        do_fetch(1'b0, "R5 DI after RETI");
    endtask

    task automatic t_prefix();
        clean();
        req_i = 5'h02;
        pulse_reti();
        prefix_i = 1;
        do_fetch(1'b0, "R6 prefixed fetch");
        prefix_i = 0;
        do_fetch(1'b1, "R6 plain fetch after prefix");
        run_entry(5'h02, 5'h02, 16'h0048, 5'h02, 0, "R6 entry a");
        pulse_ei();
        prefix_i = 1;
        do_fetch(1'b0, "R6 prefixed fetch no count");
        prefix_i = 0;
        do_fetch(1'b0, "R6 countdown still at two");
        do_fetch(1'b1, "R6 countdown done");
        run_entry(5'h02, 5'h02, 16'h0048, 5'h02, 0, "R6 entry b");
    endtask

    task automatic t_jam();
        clean();
        req_i = 5'h10;
        pulse_reti();
        jam_i = 1;
        do_fetch(1'b0, "R7 jammed fetch");
        jam_i = 0;
        do_fetch(1'b1, "R7 enable kept after jam");
        run_entry(5'h10, 5'h10, 16'h0060, 5'h10, 0, "R7 entry");
    endtask

    task automatic t_late();
        clean();
        req_i = 5'h10;
        pulse_reti();
        do_fetch(1'b1, "R10 take on source 4");
        run_entry(5'h11, 5'h11, 16'h0040, 5'h01, 0, "R10 new source wins");
        req_i = 5'h04;
        pulse_reti();
        do_fetch(1'b1, "R10 take before withdraw");
        run_entry(5'h00, 5'h00, 16'h0000, 5'h00, 0, "R10 withdrawn");
    endtask

    task automatic t_clr_gone();
        clean();
        req_i = 5'h08;
        pulse_reti();
        do_fetch(1'b1, "R11 take");
        run_entry(5'h08, 5'h00, 16'h0058, 5'h00, 0, "R11 bit dropped before clear");
    endtask

    task automatic t_mask();
        clean();
        ena_i = 5'h1E;
        req_i = 5'h01;
        #1 chk("R12 masked request", irq_o, 1'b0);
        pulse_reti();
        do_fetch(1'b0, "R9 masked source not taken");
        req_i = 5'h03;
        pulse_reti();
        #1 chk("R12 enabled request", irq_o, 1'b1);
        do_fetch(1'b1, "R9 take with mask");
        run_entry(5'h03, 5'h03, 16'h0048, 5'h02, 0, "R9 mask skips bit0");
    endtask

    task automatic t_entry_block();
        clean();
        req_i = 5'h04;
        pulse_reti();
        do_fetch(1'b1, "R13 take");
        run_entry(5'h04, 5'h04, 16'h0050, 5'h04, 1, "R13 entry");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_ei_delay();
        t_ei_repeat();
        t_reti();
        t_di();
        t_prefix();
        t_jam();
        t_late();
        t_clr_gone();
        t_mask();
        t_entry_block();
        clean();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule